// File: doc/BRIEF.md
# Sized Shift and Rotate Unit

This block is the shift and rotate path of an integer execution stage. In each cycle it takes a 64-bit value to shift, a count operand and an operand size of 1, 2, 4 or 8 bytes. The count comes either from a 64-bit register value or from an 8-bit immediate. It also takes the incoming carry flag, a 3-bit operation code and the old value of the destination register. One clock later it presents the new destination value. The result is formed at the selected width and then merged into the old destination value by the size rule used by the rest of the integer datapath.

The block supports seven operations: logical left shift, logical right shift, arithmetic right shift, rotate right, rotate left, and rotate right or left through the carry flag. The count is masked before use. If a rotate ends up with a masked count of zero, the destination keeps its value unchanged. The block does not compute condition flags.

Top module: `shrot_unit`

## Requirements
- R1: The effective count is the low 6 bits of the count operand when the size code is 3 (8 bytes), and the low 5 bits for size codes 0, 1 and 2 (1, 2 and 4 bytes).
- R2: Logical right shift (op code 1) fills the vacated upper bits of the sized word with zeros.
- R3: Logical left shift (op code 0) moves the sized word toward its top bit and fills the vacated low bits with zeros.
- R4: Arithmetic right shift (op code 2) fills the vacated upper bits with the top bit of the sized word.
- R5: When the effective count is at least the sized width, the logical shifts produce zero and the arithmetic right shift produces copies of the sign bit in every position.
- R6: For rotate right (3), rotate left (4), rotate right through carry (5) and rotate left through carry (6), an effective count of zero leaves all 64 bits of the destination unchanged. No size merge is applied in this case.
- R7: For size codes 0 (1 byte) and 1 (2 bytes), the destination bits above the sized width keep their old value. For size code 2 (4 bytes), bits 63..32 are cleared. For size code 3, all 64 bits are written.
- R8: Rotate right moves bits shifted out at the bottom of the sized word in at its top. Rotate left moves bits shifted out at the top in at its bottom.
- R9: Rotate right through carry by count c puts the incoming carry at bit (width - c) and the low source bits directly above it.
- R10: Rotate left through carry by count c puts the incoming carry at bit (c - 1) and the top (c - 1) source bits below it.
- R11: Plain rotates use the count modulo the sized width. Carry rotates use the count modulo (width + 1). A nonzero count that reduces to zero writes back the unrotated sized source, merged by R7.
- R12: Op code 7 is unused and leaves the destination unchanged.
- R13: When the immediate select is high, the count comes from the 8-bit immediate and the register count is ignored.
- R14: The result is registered: it appears one clock after the inputs, and reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (0 sll, 1 srl, 2 sra, 3 ror, 4 rol, 5 rcr, 6 rcl) |
| size_i | input | 2 | Operand size code: bytes = 1 << size_i |
| src1_i | input | 64 | Value to shift or rotate |
| src2_i | input | 64 | Register count operand |
| imm_i | input | 8 | Immediate count operand |
| use_imm_i | input | 1 | Take the count from imm_i |
| carry_i | input | 1 | Incoming carry flag |
| dest_i | input | 64 | Old destination value |
| result_o | output | 64 | New destination value, one cycle later |

## Verification
The assertions assume that every input is driven to a known value on every clock edge after reset. The clocked checks compare the registered result with the previous cycle's destination input, so they rely on `dest_i` carrying the true old register value. The stimulus drives all inputs only on the falling clock edge and holds them stable across the rising edge. It covers every op code, including the unused one, every size code, and counts that sit above the mask width, at the sized width, and at the modulo boundaries.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      SR_SLL = 3'd0,
      SR_SRL = 3'd1,
      SR_SRA = 3'd2,
      SR_ROR = 3'd3,
      SR_ROL = 3'd4,
      SR_RCR = 3'd5,
      SR_RCL = 3'd6,
      SR_NOP = 3'd7
   } sr_op_e;

   function automatic logic is_rotate(sr_op_e op);
      return (op == SR_ROR) || (op == SR_ROL) || (op == SR_RCR) || (op == SR_RCL);
   endfunction

endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
   parameter int XLEN = 64,
   parameter int IMM_W = 8,
   parameter int NSZ = 4,
   localparam int CW = $clog2(XLEN),
   localparam int SZ_W = $clog2(NSZ)
) (
   input  logic [XLEN-1:0]  cnt_reg_i,
   input  logic [IMM_W-1:0] cnt_imm_i,
   input  logic             use_imm_i,
   input  logic [SZ_W-1:0]  size_i,
   output logic [CW-1:0]    cnt_o
);

   logic [CW-1:0] raw;

   generate
      if (IMM_W >= CW) begin : g_imm_wide
         assign raw = use_imm_i ? cnt_imm_i[CW-1:0] : cnt_reg_i[CW-1:0];
      end else begin : g_imm_narrow
         assign raw = use_imm_i ? CW'(cnt_imm_i) : cnt_reg_i[CW-1:0];
      end
   endgenerate

   // Full-width operands keep every count bit; narrower ones lose the top bit.
   always_comb begin
      cnt_o = raw;
      if (size_i != SZ_W'(NSZ - 1))
         cnt_o[CW-1] = 1'b0;
   end

   always_comb begin
      if (size_i != SZ_W'(NSZ - 1))
         AST_CNT_NARROW: assert (cnt_o < CW'(XLEN / 2)); // R1
   end

endmodule

// File: rtl/shrot_core.sv
module shrot_core
   import shrot_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int W = 8,
   localparam int CW = $clog2(XLEN),
   localparam int LW = $clog2(W)
) (
   input  logic [W-1:0]    x_i,
   input  logic [CW-1:0]   cnt_i,
   input  logic            cf_i,
   input  sr_op_e          op_i,
   output logic [XLEN-1:0] res_o
);

   generate
      if (W < 8 || W > XLEN || (W & (W - 1)) != 0) begin : g_bad_w
         $error("shrot_core: W must be a power of two between 8 and XLEN");
      end
   endgenerate

   logic [LW-1:0]    rot_r;
   logic [LW:0]      rot_l;
   logic [CW:0]      rc_r;
   logic [CW:0]      rc_l;
   logic [2*W-1:0]   dbl;
   logic [2*W+1:0]   dbl_c;
   logic [2*W-1:0]   ror_t;
   logic [2*W-1:0]   rol_t;
   logic [2*W+1:0]   rcr_t;
   logic [2*W+1:0]   rcl_t;
   logic [W-1:0]     sll_v;
   logic [W-1:0]     srl_v;
   logic [W-1:0]     sra_v;
   logic [W-1:0]     res;

   // Plain rotates work modulo W; carry rotates modulo W+1.
   assign rot_r = cnt_i[LW-1:0];
   assign rot_l = (LW+1)'(W) - {1'b0, rot_r};
   assign rc_r  = (CW+1)'({1'b0, cnt_i} % (CW+1)'(W + 1));
   assign rc_l  = (CW+1)'(W + 1) - rc_r;

   assign dbl   = {x_i, x_i};
   assign dbl_c = {cf_i, x_i, cf_i, x_i};

   assign ror_t = dbl >> rot_r;
   assign rol_t = dbl >> rot_l;
   assign rcr_t = dbl_c >> rc_r;
   assign rcl_t = dbl_c >> rc_l;

   assign sll_v = x_i << cnt_i;
   assign srl_v = x_i >> cnt_i;
   assign sra_v = W'($signed(x_i) >>> cnt_i);

   always_comb begin
      unique case (op_i)
         SR_SLL:  res = sll_v;
         SR_SRL:  res = srl_v;
         SR_SRA:  res = sra_v;
         SR_ROR:  res = ror_t[W-1:0];
         SR_ROL:  res = rol_t[W-1:0];
         SR_RCR:  res = rcr_t[W-1:0];
         SR_RCL:  res = rcl_t[W-1:0];
         default: res = x_i;
      endcase
   end

   always_comb begin
      res_o = '0;
      res_o[W-1:0] = res;
   end

   always_comb begin
      if (op_i == SR_SRL && cnt_i != '0)
         AST_SRL_TOP_ZERO: assert (res[W-1] == 1'b0); // R2
      if (op_i == SR_SRA)
         AST_SRA_TOP_SIGN: assert (res[W-1] == x_i[W-1]); // R4
   end

endmodule

// File: rtl/shrot_merge.sv
module shrot_merge #(
   parameter int XLEN = 64,
   parameter int NSZ = 4,
   parameter int ZEXT_CODE = 2,
   localparam int SZ_W = $clog2(NSZ)
) (
   input  logic [SZ_W-1:0] size_i,
   input  logic [XLEN-1:0] sized_i,
   input  logic [XLEN-1:0] dest_i,
   input  logic            hold_i,
   output logic [XLEN-1:0] merged_o
);

   generate
      if (ZEXT_CODE > NSZ - 1) begin : g_bad_zext
         $error("shrot_merge: ZEXT_CODE must name an existing size");
      end
   endgenerate

   logic [XLEN-1:0] low_mask [NSZ];

   for (genvar k = 0; k < NSZ; k++) begin : g_mask
      localparam int WK = 8 << k;
      assign low_mask[k] = ~({XLEN{1'b1}} << WK);
   end

   always_comb begin
      if (hold_i)
         merged_o = dest_i;
      else if (int'(size_i) < ZEXT_CODE)
         merged_o = (dest_i & ~low_mask[size_i]) | (sized_i & low_mask[size_i]);
      else
         merged_o = sized_i & low_mask[size_i];
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int IMM_W = 8,
   parameter int ZEXT_CODE = 2,
   localparam int NSZ = $clog2(XLEN / 8) + 1,
   localparam int SZ_W = $clog2(NSZ),
   localparam int CW = $clog2(XLEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op_i,
   input  logic [SZ_W-1:0]  size_i,
   input  logic [XLEN-1:0]  src1_i,
   input  logic [XLEN-1:0]  src2_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic             use_imm_i,
   input  logic             carry_i,
   input  logic [XLEN-1:0]  dest_i,
   output logic [XLEN-1:0]  result_o
);

   generate
      if (XLEN < 16 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("shrot_unit: XLEN must be a power of two of at least 16");
      end
      if ((1 << SZ_W) != NSZ) begin : g_bad_nsz
         $error("shrot_unit: size count must fill the size code");
      end
   endgenerate

   sr_op_e          op;
   logic [CW-1:0]   cnt;
   logic [XLEN-1:0] sized_all [NSZ];
   logic [XLEN-1:0] sized;
   logic            hold;
   logic [XLEN-1:0] next_res;

   assign op = sr_op_e'(op_i);

   shrot_count #(.XLEN(XLEN), .IMM_W(IMM_W), .NSZ(NSZ)) u_count (
      .cnt_reg_i (src2_i),
      .cnt_imm_i (imm_i),
      .use_imm_i (use_imm_i),
      .size_i    (size_i),
      .cnt_o     (cnt)
   );

   for (genvar k = 0; k < NSZ; k++) begin : g_size
      localparam int WK = 8 << k;
      shrot_core #(.XLEN(XLEN), .W(WK)) u_core (
         .x_i   (src1_i[WK-1:0]),
         .cnt_i (cnt),
         .cf_i  (carry_i),
         .op_i  (op),
         .res_o (sized_all[k])
      );
   end

   assign sized = sized_all[size_i];
   assign hold  = (is_rotate(op) && cnt == '0) || (op == SR_NOP);

   shrot_merge #(.XLEN(XLEN), .NSZ(NSZ), .ZEXT_CODE(ZEXT_CODE)) u_merge (
      .size_i   (size_i),
      .sized_i  (sized),
      .dest_i   (dest_i),
      .hold_i   (hold),
      .merged_o (next_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) result_o <= '0;
      else        result_o <= next_res;
   end

   AST_ROT_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rotate(sr_op_e'(op_i)) && cnt == '0) |=> (result_o == $past(dest_i))); // R6

   AST_NARROW_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == '0) |=> (result_o[XLEN-1:8] == $past(dest_i[XLEN-1:8]))); // R7

   AST_BAD_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd7) |=> (result_o == $past(dest_i))); // R12

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] DD = 64'hDDDD_DDDD_DDDD_DDDD;

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  sz;
      logic [63:0] a;
      logic [63:0] b;
      logic        ui;
      logic [7:0]  imm;
      logic        cf;
      logic [63:0] d;
      logic [63:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 19;
   // Expected values worked out by hand from the requirements.
   localparam vec_t VECS [NV] = '{
      '{3'd0, 2'd3, 64'h1,          64'd4,    1'b0, 8'h0,  1'b0, DD, 64'h10, 8'd3},                     // R3
      '{3'd0, 2'd3, 64'h1,          64'h44,   1'b0, 8'h0,  1'b0, DD, 64'h10, 8'd1},                     // R1
      '{3'd0, 2'd2, 64'h1,          64'h24,   1'b0, 8'h0,  1'b0, DD, 64'h10, 8'd7},                     // R1 R7
      '{3'd1, 2'd0, 64'h80,         64'd3,    1'b0, 8'h0,  1'b0, DD, 64'hDDDD_DDDD_DDDD_DD10, 8'd2},    // R2
      '{3'd2, 2'd0, 64'h80,         64'd3,    1'b0, 8'h0,  1'b0, DD, 64'hDDDD_DDDD_DDDD_DDF0, 8'd4},    // R4
      '{3'd2, 2'd1, 64'h8000,       64'd20,   1'b0, 8'h0,  1'b0, DD, 64'hDDDD_DDDD_DDDD_FFFF, 8'd5},    // R5
      '{3'd0, 2'd1, 64'h1234,       64'd17,   1'b0, 8'h0,  1'b0, DD, 64'hDDDD_DDDD_DDDD_0000, 8'd5},    // R5
      '{3'd2, 2'd3, 64'h8000_0000_0000_0000, 64'd63, 1'b0, 8'h0, 1'b0, DD, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5}, // R5
      '{3'd3, 2'd0, 64'h01,         64'd1,    1'b0, 8'h0,  1'b0, DD, 64'hDDDD_DDDD_DDDD_DD80, 8'd8},    // R8
      '{3'd4, 2'd1, 64'h8001,       64'd4,    1'b0, 8'h0,  1'b0, DD, 64'hDDDD_DDDD_DDDD_0018, 8'd8},    // R8
      '{3'd3, 2'd3, 64'h1234,       64'h40,   1'b0, 8'h0,  1'b0, DD, DD, 8'd6},                         // R6
      '{3'd4, 2'd2, 64'h1234,       64'h20,   1'b0, 8'h0,  1'b1, DD, DD, 8'd6},                         // R6
      '{3'd5, 2'd0, 64'h01,         64'd2,    1'b0, 8'h0,  1'b1, DD, 64'hDDDD_DDDD_DDDD_DDC0, 8'd9},    // R9
      '{3'd5, 2'd3, 64'h0,          64'd1,    1'b0, 8'h0,  1'b1, DD, 64'h8000_0000_0000_0000, 8'd9},    // R9
      '{3'd6, 2'd0, 64'h80,         64'd2,    1'b0, 8'h0,  1'b1, DD, 64'hDDDD_DDDD_DDDD_DD03, 8'd10},   // R10
      '{3'd6, 2'd0, 64'h5A,         64'd9,    1'b0, 8'h0,  1'b1, DD, 64'hDDDD_DDDD_DDDD_DD5A, 8'd11},   // R11
      '{3'd3, 2'd0, 64'h5A,         64'd8,    1'b0, 8'h0,  1'b0, DD, 64'hDDDD_DDDD_DDDD_DD5A, 8'd11},   // R11
      '{3'd7, 2'd3, 64'hFFFF,       64'd3,    1'b0, 8'h0,  1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 8'd12}, // R12
      '{3'd1, 2'd3, 64'hF0,         64'h3F,   1'b1, 8'h04, 1'b0, DD, 64'h0F, 8'd13}                     // R13
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = '0;
   logic [1:0]  size_i = '0;
   logic [63:0] src1_i = '0;
   logic [63:0] src2_i = '0;
   logic [7:0]  imm_i = '0;
   logic        use_imm_i = 1'b0;
   logic        carry_i = 1'b0;
   logic [63:0] dest_i = '0;
   logic [63:0] result_o;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shrot_unit u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (op_i),
      .size_i    (size_i),
      .src1_i    (src1_i),
      .src2_i    (src2_i),
      .imm_i     (imm_i),
      .use_imm_i (use_imm_i),
      .carry_i   (carry_i),
      .dest_i    (dest_i),
      .result_o  (result_o)
   );

   task automatic check(input logic [63:0] exp, input int req, input string what);
      total++;
      if (result_o !== exp) begin
         bad++;
         $display("FAIL R%0d %s: actual=%h expected=%h", req, what, result_o, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      op_i      = v.op;
      size_i    = v.sz;
      src1_i    = v.a;
      src2_i    = v.b;
      use_imm_i = v.ui;
      imm_i     = v.imm;
      carry_i   = v.cf;
      dest_i    = v.d;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      // R14: reset clears the result even with active inputs
      drive(VECS[0]);
      repeat (3) @(negedge clk);
      check(64'h0, 14, "reset state");

      @(negedge clk);
      rst_n = 1'b1;

      // Table walk: drive at a falling edge, sample at the next one.
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
      end

      // R14: one-cycle latency; the old result stays until the next edge
      drive(VECS[0]);
      @(negedge clk);
      check(64'h10, 14, "latency setup");
      drive(VECS[3]);
      #1;
      check(64'h10, 14, "no combinational path");
      @(negedge clk);
      check(64'hDDDD_DDDD_DDDD_DD10, 14, "latency result");

      // R13: immediate mode ignores a register count of zero
      drive(VECS[NV-1]);
      src2_i = 64'h0;
      imm_i  = 8'h08;
      @(negedge clk);
      check(64'h0, 13, "immediate count 8 clears 0xF0");

      // R1 R11: a byte rotate by 32 masks to zero and holds
      op_i = 3'd5; size_i = 2'd0; use_imm_i = 1'b0;
      src1_i = 64'h77; src2_i = 64'h20; carry_i = 1'b1; dest_i = 64'h1111_2222_3333_4444;
      @(negedge clk);
      check(64'h1111_2222_3333_4444, 6, "masked zero carry rotate");

      // R7: a full-width write replaces every bit
      op_i = 3'd0; size_i = 2'd3; src1_i = 64'hA5A5_0000_0000_0001; src2_i = 64'd0; dest_i = DD;
      @(negedge clk);
      check(64'hA5A5_0000_0000_0001, 7, "full width zero shift");

      // R14: a reset in mid-run clears the result again
      rst_n = 1'b0;
      @(negedge clk);
      check(64'h0, 14, "mid-run reset");
      rst_n = 1'b1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule